// File: doc/BRIEF.md
# Dual-Clock Two-Port Synchronous Word Memory

This block is a shared word store with two fully independent access ports, called left and right. Each port has its own clock, its own address, its own read/write strobe, byte-lane enables, a pair of chip selects, an address-load strobe, an output enable and a sleep request. Either port may read or write any location at any time. A word written through one port can be read back through the other. The word is made of `LANES` byte lanes of `LANE_W` bits each. The defaults are four lanes of nine bits, which gives 36 bits.

Each port has a static mode input that picks its read latency. In flow-through mode the data for an address sampled on a rising edge is presented right after that edge. In pipelined mode the data passes through an output register and appears one edge later. The memory has no tri-state pads. Each byte of read data instead carries an output-valid flag, and a low flag stands for a lane that is not driven.

Each port runs a small sleep state machine with five states:
- `SLP_AWAKE`: normal operation.
- `SLP_ENTER`: the request has been seen and accesses are still served.
- `SLP_ASLEEP`: accesses are ignored.
- `SLP_WAKE1` and `SLP_WAKE2`: the request has been released and the port is recovering.

The transitions are as follows:
- A request seen in `SLP_AWAKE` moves the port to `SLP_ENTER`.
- In `SLP_ENTER`, a held request moves the port to `SLP_ASLEEP`, and a dropped request returns it to `SLP_AWAKE`.
- In `SLP_ASLEEP`, a release moves the port to `SLP_WAKE1`.
- From `SLP_WAKE1` the port goes to `SLP_WAKE2`, and from `SLP_WAKE2` to `SLP_AWAKE`, each step taken only while the request stays released.
- A request seen in either wake state sends the port back to `SLP_ASLEEP`.

Top module: `dpsram_dual`

## Requirements
- R1: With `flow_x`=1, a read issued on a rising edge (select active, `rw_x`=1) presents the addressed word on `rdata_x` right after that edge. `rvalid_x` bit i is set for each lane i whose `be_n_x` bit i was 0.
- R2: With `flow_x`=0, the read word and its lane flags appear only after the next rising edge. Right after the issuing edge, `rvalid_x` still reflects the access made one edge earlier.
- R3: A port is selected only when `ce0_n_x`=0 and `ce1_x`=1. A write while deselected changes nothing. When a port is deselected at an edge, its flow-through lane flags are all 0 after that edge.
- R4: Lane i (bits 9i+8..9i with the defaults) is written only when `be_n_x[i]`=0. A read with `be_n_x[i]`=1 leaves `rvalid_x[i]` at 0.
- R5: When `ads_n_x`=0 on an edge, the access uses `addr_x` and that address is stored. When `ads_n_x`=1, the access uses the stored address and `addr_x` is ignored.
- R6: While `oe_n_x`=1, `rvalid_x` is all 0 at once, with no clock edge needed. Pulling `oe_n_x` low again shows the held read data and flags unchanged.
- R7: Suppose `sleep_x` is first sampled high on edge e1 and stays high. Accesses on e1 and e2 are served, and accesses from e3 onward are ignored.
- R8: Suppose `sleep_x` is first sampled low on edge w1 after sleep and stays low. Accesses on w1, w2 and w3 are ignored, and the access on w4 is served.
- R9: While a port sleeps, its writes are ignored and its reads leave `rvalid_x` at 0. Stored contents are kept.
- R10: A word written on one port is returned by a later read on the other port. When both ports write the same address at different times, each lane returns the value of the most recent write to that lane.
- R11: While `rst_n`=0, both ports report `rvalid` all 0 and their sleep state machines are in `SLP_AWAKE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of port control state |
| clk_l | input | 1 | Left port clock |
| addr_l | input | AW | Left address |
| rw_l | input | 1 | Left strobe, 1 = read, 0 = write |
| be_n_l | input | LANES | Left lane enables, active low |
| ce0_n_l | input | 1 | Left chip select, active low |
| ce1_l | input | 1 | Left chip select, active high |
| ads_n_l | input | 1 | Left address-load strobe, active low |
| oe_n_l | input | 1 | Left asynchronous output enable, active low |
| flow_l | input | 1 | Left static mode, 1 = flow-through, 0 = pipelined |
| sleep_l | input | 1 | Left sleep request |
| wdata_l | input | LANES*LANE_W | Left write data |
| rdata_l | output | LANES*LANE_W | Left read data |
| rvalid_l | output | LANES | Left per-lane output-valid flags |
| clk_r | input | 1 | Right port clock |
| addr_r | input | AW | Right address |
| rw_r | input | 1 | Right strobe, 1 = read, 0 = write |
| be_n_r | input | LANES | Right lane enables, active low |
| ce0_n_r | input | 1 | Right chip select, active low |
| ce1_r | input | 1 | Right chip select, active high |
| ads_n_r | input | 1 | Right address-load strobe, active low |
| oe_n_r | input | 1 | Right asynchronous output enable, active low |
| flow_r | input | 1 | Right static mode, 1 = flow-through, 0 = pipelined |
| sleep_r | input | 1 | Right sleep request |
| wdata_r | input | LANES*LANE_W | Right write data |
| rdata_r | output | LANES*LANE_W | Right read data |
| rvalid_r | output | LANES | Right per-lane output-valid flags |

## Verification
The bench checks the exact edge at which read data appears in each mode. A pipelined port that lost its output register would show data one edge early, and a flow-through port that gained one would show it one edge late. It writes two lanes of one word from opposite ports. A memory that tracked the most recent writer per word rather than per lane would return a stale lane. It counts the edges across sleep entry and release, which exposes any state machine that is one state short or one state long. It also toggles the output enable between clock edges, which exposes a design that waits for a clock or loses its held read data.

// File: rtl/dpsram_pkg.sv
package dpsram_pkg;

    typedef enum logic [2:0] {
        SLP_AWAKE  = 3'd0,
        SLP_ENTER  = 3'd1,
        SLP_ASLEEP = 3'd2,
        SLP_WAKE1  = 3'd3,
        SLP_WAKE2  = 3'd4
    } slp_state_t;

endpackage

// File: rtl/dpsram_sleep_fsm.sv
module dpsram_sleep_fsm
    import dpsram_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    output logic dormant
);

    slp_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLP_AWAKE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLP_AWAKE:  if (sleep_req) state_d = SLP_ENTER;
            SLP_ENTER:  state_d = sleep_req ? SLP_ASLEEP : SLP_AWAKE;
            SLP_ASLEEP: if (!sleep_req) state_d = SLP_WAKE1;
            SLP_WAKE1:  state_d = sleep_req ? SLP_ASLEEP : SLP_WAKE2;
            SLP_WAKE2:  state_d = sleep_req ? SLP_ASLEEP : SLP_AWAKE;
            default:    state_d = SLP_AWAKE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            SLP_ASLEEP, SLP_WAKE1, SLP_WAKE2: dormant = 1'b1;
            default:                          dormant = 1'b0;
        endcase
    end

endmodule

// File: rtl/dpsram_bank.sv
module dpsram_bank #(
    parameter int DEPTH  = 256,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    parameter bit FLIP   = 1'b0,
    localparam int AW    = $clog2(DEPTH),
    localparam int WW    = LANES * LANE_W
) (
    input  logic             clk,
    input  logic [LANES-1:0] we,
    input  logic [AW-1:0]    waddr,
    input  logic [WW-1:0]    wdata,
    input  logic [LANES-1:0] peer_tag,
    input  logic [AW-1:0]    raddr_a,
    input  logic [AW-1:0]    raddr_b,
    input  logic [AW-1:0]    taddr,
    output logic [WW-1:0]    rdata_a,
    output logic [WW-1:0]    rdata_b,
    output logic [LANES-1:0] rtag_a,
    output logic [LANES-1:0] rtag_b,
    output logic [LANES-1:0] ttag
);

    logic [WW-1:0]    mem  [DEPTH];
    logic [LANES-1:0] tags [DEPTH];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (we[i]) begin
                mem[waddr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
                tags[waddr][i]                 <= peer_tag[i] ^ FLIP;
            end
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
    assign rtag_a  = tags[raddr_a];
    assign rtag_b  = tags[raddr_b];
    assign ttag    = tags[taddr];

endmodule

// File: rtl/dpsram_port.sv
module dpsram_port #(
    parameter int DEPTH  = 256,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int AW    = $clog2(DEPTH),
    localparam int WW    = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr,
    input  logic             rw,
    input  logic [LANES-1:0] be_n,
    input  logic             ce0_n,
    input  logic             ce1,
    input  logic             ads_n,
    input  logic             oe_n,
    input  logic             flow,
    input  logic             sleep_req,
    input  logic [WW-1:0]    rd_word,
    output logic [LANES-1:0] we,
    output logic [AW-1:0]    acc_addr,
    output logic [AW-1:0]    rd_addr,
    output logic [WW-1:0]    rdata,
    output logic [LANES-1:0] rvalid
);

    logic             dormant;
    logic             sel;
    logic [AW-1:0]    addr_hold;
    logic [LANES-1:0] rd_lane_q;
    logic [LANES-1:0] pipe_lane;
    logic [WW-1:0]    pipe_word;
    logic [LANES-1:0] lanes_out;

    dpsram_sleep_fsm u_slp (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_req (sleep_req),
        .dormant   (dormant)
    );

    assign sel      = !ce0_n && ce1;
    assign acc_addr = ads_n ? addr_hold : addr;
    assign we       = (sel && !rw && !dormant) ? ~be_n : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_hold <= '0;
            rd_addr   <= '0;
            rd_lane_q <= '0;
            pipe_lane <= '0;
            pipe_word <= '0;
        end else begin
            if (!ads_n) addr_hold <= addr;
            rd_addr   <= acc_addr;
            rd_lane_q <= (sel && rw && !dormant) ? ~be_n : '0;
            pipe_lane <= rd_lane_q;
            pipe_word <= rd_word;
        end
    end

    assign rdata     = flow ? rd_word : pipe_word;
    assign lanes_out = flow ? rd_lane_q : pipe_lane;
    assign rvalid    = oe_n ? '0 : lanes_out;

endmodule

// File: rtl/dpsram_dual.sv
module dpsram_dual #(
    parameter int DEPTH  = 256,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int AW    = $clog2(DEPTH),
    localparam int WW    = LANES * LANE_W
) (
    input  logic             rst_n,
    input  logic             clk_l,
    input  logic [AW-1:0]    addr_l,
    input  logic             rw_l,
    input  logic [LANES-1:0] be_n_l,
    input  logic             ce0_n_l,
    input  logic             ce1_l,
    input  logic             ads_n_l,
    input  logic             oe_n_l,
    input  logic             flow_l,
    input  logic             sleep_l,
    input  logic [WW-1:0]    wdata_l,
    output logic [WW-1:0]    rdata_l,
    output logic [LANES-1:0] rvalid_l,
    input  logic             clk_r,
    input  logic [AW-1:0]    addr_r,
    input  logic             rw_r,
    input  logic [LANES-1:0] be_n_r,
    input  logic             ce0_n_r,
    input  logic             ce1_r,
    input  logic             ads_n_r,
    input  logic             oe_n_r,
    input  logic             flow_r,
    input  logic             sleep_r,
    input  logic [WW-1:0]    wdata_r,
    output logic [WW-1:0]    rdata_r,
    output logic [LANES-1:0] rvalid_r
);

    logic [LANES-1:0] we_l, we_r;
    logic [AW-1:0]    wa_l, wa_r, ra_l, ra_r;
    logic [WW-1:0]    word_l, word_r;
    logic [WW-1:0]    bl_dl, bl_dr, br_dl, br_dr;
    logic [LANES-1:0] bl_tl, bl_tr, br_tl, br_tr, bl_tt, br_tt;

    dpsram_port #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_port_l (
        .clk(clk_l), .rst_n(rst_n), .addr(addr_l), .rw(rw_l), .be_n(be_n_l),
        .ce0_n(ce0_n_l), .ce1(ce1_l), .ads_n(ads_n_l), .oe_n(oe_n_l),
        .flow(flow_l), .sleep_req(sleep_l), .rd_word(word_l), .we(we_l),
        .acc_addr(wa_l), .rd_addr(ra_l), .rdata(rdata_l), .rvalid(rvalid_l)
    );

    dpsram_port #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_port_r (
        .clk(clk_r), .rst_n(rst_n), .addr(addr_r), .rw(rw_r), .be_n(be_n_r),
        .ce0_n(ce0_n_r), .ce1(ce1_r), .ads_n(ads_n_r), .oe_n(oe_n_r),
        .flow(flow_r), .sleep_req(sleep_r), .rd_word(word_r), .we(we_r),
        .acc_addr(wa_r), .rd_addr(ra_r), .rdata(rdata_r), .rvalid(rvalid_r)
    );

    dpsram_bank #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W), .FLIP(1'b0)) u_bank_l (
        .clk(clk_l), .we(we_l), .waddr(wa_l), .wdata(wdata_l), .peer_tag(br_tt),
        .raddr_a(ra_l), .raddr_b(ra_r), .taddr(wa_r),
        .rdata_a(bl_dl), .rdata_b(bl_dr), .rtag_a(bl_tl), .rtag_b(bl_tr), .ttag(bl_tt)
    );

    dpsram_bank #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W), .FLIP(1'b1)) u_bank_r (
        .clk(clk_r), .we(we_r), .waddr(wa_r), .wdata(wdata_r), .peer_tag(bl_tt),
        .raddr_a(ra_l), .raddr_b(ra_r), .taddr(wa_l),
        .rdata_a(br_dl), .rdata_b(br_dr), .rtag_a(br_tl), .rtag_b(br_tr), .ttag(br_tt)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_merge
        assign word_l[i*LANE_W +: LANE_W] = (bl_tl[i] == br_tl[i]) ?
            bl_dl[i*LANE_W +: LANE_W] : br_dl[i*LANE_W +: LANE_W];
        assign word_r[i*LANE_W +: LANE_W] = (bl_tr[i] == br_tr[i]) ?
            bl_dr[i*LANE_W +: LANE_W] : br_dr[i*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/dpsram_dual_chk.sv
module dpsram_dual_chk #(
    parameter int LANES = 4
) (
    input logic             rst_n,
    input logic             clk_l,
    input logic             clk_r,
    input logic             oe_n_l,
    input logic             oe_n_r,
    input logic             flow_l,
    input logic             flow_r,
    input logic             ce0_n_l,
    input logic             ce1_l,
    input logic             ce0_n_r,
    input logic             ce1_r,
    input logic [LANES-1:0] be_n_r,
    input logic             sleep_r,
    input logic [LANES-1:0] rvalid_l,
    input logic [LANES-1:0] rvalid_r
);

    // R6: output enable high blanks every lane flag
    p_oe_blank_r6: assert property (@(posedge clk_l) disable iff (!rst_n)
        oe_n_l |-> rvalid_l == '0);

    // R3: flow-through port deselected at an edge shows no lanes after it
    p_flow_desel_r3: assert property (@(posedge clk_r) disable iff (!rst_n)
        (flow_r && !(!ce0_n_r && ce1_r)) |=> rvalid_r == '0);

    // R2: pipelined port deselected at an edge shows no lanes one edge later
    p_pipe_desel_r2: assert property (@(posedge clk_l) disable iff (!rst_n)
        (!flow_l && !(!ce0_n_l && ce1_l)) |=> ##1 rvalid_l == '0);

    // R4: a disabled lane on a flow-through read stays invalid
    p_lane_off_r4: assert property (@(posedge clk_r) disable iff (!rst_n)
        (flow_r && be_n_r[0]) |=> !rvalid_r[0]);

    // R7: three sampled edges of sleep request blank a flow-through read
    p_sleep_in_r7: assert property (@(posedge clk_r) disable iff (!rst_n)
        (flow_r && sleep_r && $past(sleep_r) && $past(sleep_r, 2)) |=> rvalid_r == '0);

endmodule

bind dpsram_dual dpsram_dual_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/dpsram_dual_tb_top.sv
module dpsram_dual_tb_top;

    localparam int AW = 8;
    localparam int WW = 36;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr_l, addr_r;
    logic          rw_l, rw_r, ce0_n_l, ce0_n_r, ce1_l, ce1_r, ads_n_l, ads_n_r;
    logic          oe_n_l, oe_n_r, flow_l, flow_r, sleep_l, sleep_r;
    logic [3:0]    be_n_l, be_n_r, rvalid_l, rvalid_r;
    logic [WW-1:0] wdata_l, wdata_r, rdata_l, rdata_r;

    int n_chk  = 0;
    int n_fail = 0;

    localparam logic [43:0] VEC [6] = '{
        {8'h03, 36'h123456789}, {8'h10, 36'hFEDCBA987}, {8'h7F, 36'h0A5A5A5A5},
        {8'h80, 36'h5A5A5A5A0}, {8'hFF, 36'h000000001}, {8'h00, 36'h800000000}
    };

    always #4 clk = ~clk;

    dpsram_dual dut_i (
        .rst_n(rst_n),
        .clk_l(clk), .addr_l(addr_l), .rw_l(rw_l), .be_n_l(be_n_l), .ce0_n_l(ce0_n_l),
        .ce1_l(ce1_l), .ads_n_l(ads_n_l), .oe_n_l(oe_n_l), .flow_l(flow_l),
        .sleep_l(sleep_l), .wdata_l(wdata_l), .rdata_l(rdata_l), .rvalid_l(rvalid_l),
        .clk_r(clk), .addr_r(addr_r), .rw_r(rw_r), .be_n_r(be_n_r), .ce0_n_r(ce0_n_r),
        .ce1_r(ce1_r), .ads_n_r(ads_n_r), .oe_n_r(oe_n_r), .flow_r(flow_r),
        .sleep_r(sleep_r), .wdata_r(wdata_r), .rdata_r(rdata_r), .rvalid_r(rvalid_r)
    );

    task automatic chk(input string req, input logic [WW-1:0] got, input logic [WW-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic idle;
        ce0_n_l = 1'b1; ce1_l = 1'b1; rw_l = 1'b1; be_n_l = 4'h0; ads_n_l = 1'b0;
        ce0_n_r = 1'b1; ce1_r = 1'b1; rw_r = 1'b1; be_n_r = 4'h0; ads_n_r = 1'b0;
    endtask

    task automatic l_acc(input logic rd, input logic [AW-1:0] a, input logic [WW-1:0] d,
                         input logic [3:0] ben);
        ce0_n_l = 1'b0; ce1_l = 1'b1; rw_l = rd; addr_l = a; wdata_l = d;
        be_n_l = ben; ads_n_l = 1'b0;
    endtask

    task automatic r_acc(input logic rd, input logic [AW-1:0] a, input logic [WW-1:0] d,
                         input logic [3:0] ben);
        ce0_n_r = 1'b0; ce1_r = 1'b1; rw_r = rd; addr_r = a; wdata_r = d;
        be_n_r = ben; ads_n_r = 1'b0;
    endtask

    function automatic logic [WW-1:0] merge(input logic [WW-1:0] old_w,
                                            input logic [WW-1:0] new_w,
                                            input logic [3:0] ben);
        logic [WW-1:0] res = old_w;
        for (int i = 0; i < 4; i++)
            if (!ben[i]) res[i*9 +: 9] = new_w[i*9 +: 9];
        return res;
    endfunction

    initial begin
        #(8 * 20000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [WW-1:0] a_w, exp_w;
        rst_n = 1'b0; idle();
        addr_l = '0; addr_r = '0; wdata_l = '0; wdata_r = '0;
        oe_n_l = 1'b0; oe_n_r = 1'b0; flow_l = 1'b0; flow_r = 1'b1;
        sleep_l = 1'b0; sleep_r = 1'b0;
        repeat (3) tick();
        chk("R11 reset rvalid_l", rvalid_l, '0);
        chk("R11 reset rvalid_r", rvalid_r, '0);
        rst_n = 1'b1;
        tick();

        // table walk: left writes, right flow-through reads, left pipelined reads
        for (int i = 0; i < 6; i++) begin
            l_acc(1'b0, VEC[i][43:36], VEC[i][35:0], 4'h0); tick(); idle();
            r_acc(1'b1, VEC[i][43:36], '0, 4'h0); tick();
            chk("R1 R10 flow data", rdata_r, VEC[i][35:0]);
            chk("R1 flow lanes", rvalid_r, 4'hF);
            idle(); tick();
            chk("R3 deselect lanes", rvalid_r, '0);
            l_acc(1'b1, VEC[i][43:36], '0, 4'h0); tick();
            chk("R2 not yet valid", rvalid_l, '0);
            idle(); tick();
            chk("R2 pipe data", rdata_l, VEC[i][35:0]);
            chk("R2 pipe lanes", rvalid_l, 4'hF);
        end

        // R3: write with ce1 low is ignored
        l_acc(1'b0, VEC[0][43:36], 36'h777777777, 4'h0); ce1_l = 1'b0; tick(); idle();
        r_acc(1'b1, VEC[0][43:36], '0, 4'h0); tick();
        chk("R3 deselected write ignored", rdata_r, VEC[0][35:0]);
        idle(); tick();

        // R4: lane-masked write and read
        l_acc(1'b0, VEC[0][43:36], 36'hABCDEF012, 4'b0101); tick(); idle();
        exp_w = merge(VEC[0][35:0], 36'hABCDEF012, 4'b0101);
        r_acc(1'b1, VEC[0][43:36], '0, 4'b0011); tick();
        chk("R4 lane write data", rdata_r, exp_w);
        chk("R4 lane flags", rvalid_r, 4'b1100);
        idle(); tick();

        // R10: latest writer per lane across ports
        a_w = 36'h0F0F0F0F0;
        l_acc(1'b0, VEC[1][43:36], a_w, 4'h0); tick(); idle();
        r_acc(1'b0, VEC[1][43:36], 36'h0000001FF, 4'b1110); tick(); idle();
        l_acc(1'b1, VEC[1][43:36], '0, 4'h0); tick(); idle(); tick();
        chk("R10 right lane wins", rdata_l, {a_w[35:9], 9'h1FF});
        l_acc(1'b0, VEC[1][43:36], 36'h000000055, 4'b1110); tick(); idle();
        r_acc(1'b1, VEC[1][43:36], '0, 4'h0); tick();
        chk("R10 left lane wins", rdata_r, {a_w[35:9], 9'h055});
        idle(); tick();

        // R5: held address when ads_n is high
        r_acc(1'b1, VEC[2][43:36], '0, 4'h0); tick();
        chk("R5 loaded address", rdata_r, VEC[2][35:0]);
        addr_r = VEC[3][43:36]; ads_n_r = 1'b1; tick();
        chk("R5 held address", rdata_r, VEC[2][35:0]);
        idle(); tick();

        // R6: asynchronous output enable, flow and pipelined
        r_acc(1'b1, VEC[2][43:36], '0, 4'h0); tick(); idle();
        oe_n_r = 1'b1; #1;
        chk("R6 oe blanks flow", rvalid_r, '0);
        oe_n_r = 1'b0; #1;
        chk("R6 oe restores flow", rvalid_r, 4'hF);
        tick();
        l_acc(1'b1, VEC[3][43:36], '0, 4'h0); tick(); idle(); tick();
        oe_n_l = 1'b1; #1;
        chk("R6 oe blanks pipe", rvalid_l, '0);
        oe_n_l = 1'b0; #1;
        chk("R6 pipe held data", rdata_l, VEC[3][35:0]);
        chk("R6 pipe held lanes", rvalid_l, 4'hF);
        tick();

        // R7: sleep entry
        r_acc(1'b1, VEC[2][43:36], '0, 4'h0); sleep_r = 1'b1;
        tick(); chk("R7 e1 served", rvalid_r, 4'hF);
        tick(); chk("R7 e2 served", rvalid_r, 4'hF);
        tick(); chk("R7 e3 ignored", rvalid_r, '0);
        // R9: write during sleep ignored
        r_acc(1'b0, VEC[2][43:36], 36'h3C3C3C3C3, 4'h0); tick(); tick();
        chk("R9 read blank asleep", rvalid_r, '0);
        // R8: recovery
        r_acc(1'b1, VEC[2][43:36], '0, 4'h0); sleep_r = 1'b0;
        tick(); chk("R8 w1 ignored", rvalid_r, '0);
        tick(); chk("R8 w2 ignored", rvalid_r, '0);
        tick(); chk("R8 w3 ignored", rvalid_r, '0);
        tick(); chk("R8 w4 served", rvalid_r, 4'hF);
        chk("R9 contents kept", rdata_r, VEC[2][35:0]);
        idle(); tick();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule